// File: doc/BRIEF.md
# Reset Cause Capture and Merge Unit

This block gathers the reset requests of a small system into a single system reset and remembers which request caused the most recent one. Six hardware sources arrive as request pulses: supply monitor, external reset pin, missing-clock detector, watchdog timeout, comparator and flash-access error. A seventh source is software. Software can force a reset by writing the block's 8-bit status register on a simple register bus.

The register works differently for reads and writes. A read returns one latched cause flag per source. A write sets the enables of three gated sources (comparator, missing-clock, supply monitor) and may trigger the software reset. Each write is taken as a complete new value, because software is not expected to read, modify and write this register.

The active-low asynchronous input `rst_ni` is the power-on reset. It reports itself through the same flag as the supply monitor. The system reset output stays high for a fixed number of cycles after the last qualifying request has gone away.

Top module: `reset_cause_unit`

## Requirements
- R1: While `rst_ni` is low, reads return 0x02 (power-on flag only) and `sys_rst_o` is high. After release, `sys_rst_o` stays high for exactly HOLD_CYCLES (default 16) clock cycles and then falls.
- R2: Bit 7 of the register always reads 0. A write with bit 7 set behaves like the same write with bit 7 clear.
- R3: A pin, watchdog or flash-error request always causes a reset. Afterwards exactly one flag reads 1: bit 0 (pin), bit 3 (watchdog) or bit 6 (flash error).
- R4: A write with bit 4 set forces a reset, and bit 4 then reads 1. A write with bit 4 clear causes no reset.
- R5: Write bit 5 enables the comparator as a reset source. When enabled, a comparator request resets and sets read bit 5. When disabled, the request is ignored and the flags are unchanged.
- R6: Write bit 2 enables the missing-clock source in the same way, and its cause flag is read bit 2.
- R7: Write bit 1 enables the supply monitor. When enabled, a supply request resets the system and read bit 1 is set, with every other flag at the POR_FLAG_FILL value (default 0).
- R8: The three enables keep their values across resets from any source other than `rst_ni`. The `rst_ni` reset clears the comparator and missing-clock enables and sets the supply-monitor enable.
- R9: `sys_rst_o` is high in the cycle after any qualifying request. It stays high for HOLD_CYCLES cycles after the last cycle in which a request was present, so a new request during the hold restarts the count.
- R10: When several qualifying requests arrive in one cycle, only the winner's flag is set. Priority from highest to lowest is supply/power-on, pin, missing-clock, watchdog, comparator, flash error, software.
- R11: The register answers only at address ADDR (default 0xEF). Reads at any other address return 0, and writes to other addresses have no effect.
- R12: Register writes made while `sys_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sup_req_i | input | 1 | Supply-monitor reset request |
| pin_req_i | input | 1 | External pin reset request |
| mcd_req_i | input | 1 | Missing-clock detector timeout |
| wdog_req_i | input | 1 | Watchdog timeout |
| cmp_req_i | input | 1 | Comparator reset request |
| flash_req_i | input | 1 | Flash-access error |
| bus_wr_i | input | 1 | Register bus write strobe |
| bus_addr_i | input | 8 | Register bus address |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data (combinational on address) |
| sys_rst_o | output | 1 | Merged system reset, active high |

## Verification
The hardest case is several sources firing in the same cycle, combined with each possible setting of the source enables. A software reset can only join such a cycle if a bus write lands in exactly that clock cycle. The bench therefore drives all 128 subsets of the seven sources in a single cycle, with the software source expressed as a register write, under all eight enable combinations. For each case it computes the masked winner, the expected flag byte and the hold length arithmetically. Directed sequences then cover the remaining corners: hold restart, writes during the hold, writes to other addresses, and enable retention versus power-on clearing.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned NSRC   = 7;
  localparam int unsigned FLAG_W = 7;

  // arbitration index, lowest wins
  localparam int unsigned IDX_SUP   = 0;
  localparam int unsigned IDX_PIN   = 1;
  localparam int unsigned IDX_MCD   = 2;
  localparam int unsigned IDX_WDOG  = 3;
  localparam int unsigned IDX_CMP   = 4;
  localparam int unsigned IDX_FLASH = 5;
  localparam int unsigned IDX_SW    = 6;

  // register bit positions (software decodes these)
  localparam int unsigned BIT_PIN   = 0;
  localparam int unsigned BIT_SUP   = 1;
  localparam int unsigned BIT_MCD   = 2;
  localparam int unsigned BIT_WDOG  = 3;
  localparam int unsigned BIT_SW    = 4;
  localparam int unsigned BIT_CMP   = 5;
  localparam int unsigned BIT_FLASH = 6;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      IDX_SUP:   return BIT_SUP;
      IDX_PIN:   return BIT_PIN;
      IDX_MCD:   return BIT_MCD;
      IDX_WDOG:  return BIT_WDOG;
      IDX_CMP:   return BIT_CMP;
      IDX_FLASH: return BIT_FLASH;
      default:   return BIT_SW;
    endcase
  endfunction
endpackage

// File: rtl/rcc_src_arbiter.sv
module rcc_src_arbiter #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/rcc_cfg_regs.sv
module rcc_cfg_regs
  import rcc_pkg::*;
#(
  parameter int unsigned AW             = 8,
  parameter int unsigned DW             = 8,
  parameter logic [AW-1:0] ADDR         = 8'hEF,
  parameter logic        SUP_EN_DEFAULT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          blocked_i,
  output logic          en_cmp_o,
  output logic          en_mcd_o,
  output logic          en_sup_o,
  output logic          sw_req_o
);
  logic hit;
  logic unused_wbits;

  assign hit      = wr_i && (addr_i == ADDR) && !blocked_i;
  assign sw_req_o = hit && wdata_i[BIT_SW];
  assign unused_wbits = ^{wdata_i[DW-1:BIT_FLASH], wdata_i[BIT_WDOG], wdata_i[BIT_PIN]};

  // whole-value write, no read-modify-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cmp_o <= 1'b0;
      en_mcd_o <= 1'b0;
      en_sup_o <= SUP_EN_DEFAULT;
    end else if (hit) begin
      en_cmp_o <= wdata_i[BIT_CMP];
      en_mcd_o <= wdata_i[BIT_MCD];
      en_sup_o <= wdata_i[BIT_SUP];
    end
  end

  p_keep_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> ($stable(en_cmp_o) && $stable(en_mcd_o) && $stable(en_sup_o)));

  p_blocked_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_i |-> !sw_req_o);
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LOAD;
    else if (trig_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  initial begin
    assert (HOLD >= 1) else $error("HOLD must be at least 1");
  end

  p_trig_asserts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o);

  p_hold_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcc_pkg::*;
#(
  parameter logic [7:0]  ADDR           = 8'hEF,
  parameter int unsigned HOLD_CYCLES    = 16,
  parameter logic        POR_FLAG_FILL  = 1'b0,
  parameter logic        SUP_EN_DEFAULT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sup_req_i,
  input  logic       pin_req_i,
  input  logic       mcd_req_i,
  input  logic       wdog_req_i,
  input  logic       cmp_req_i,
  input  logic       flash_req_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       sys_rst_o
);
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;

  logic                en_cmp, en_mcd, en_sup, sw_req;
  logic [NSRC-1:0]     req_vec, grant;
  logic                any_req;
  logic [FLAG_W-1:0]   flags_q, flags_d, por_pattern;

  rcc_cfg_regs #(
    .AW(AW), .DW(DW), .ADDR(ADDR), .SUP_EN_DEFAULT(SUP_EN_DEFAULT)
  ) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .blocked_i (sys_rst_o),
    .en_cmp_o  (en_cmp),
    .en_mcd_o  (en_mcd),
    .en_sup_o  (en_sup),
    .sw_req_o  (sw_req)
  );

  always_comb begin
    req_vec            = '0;
    req_vec[IDX_SUP]   = sup_req_i & en_sup;
    req_vec[IDX_PIN]   = pin_req_i;
    req_vec[IDX_MCD]   = mcd_req_i & en_mcd;
    req_vec[IDX_WDOG]  = wdog_req_i;
    req_vec[IDX_CMP]   = cmp_req_i & en_cmp;
    req_vec[IDX_FLASH] = flash_req_i;
    req_vec[IDX_SW]    = sw_req;
  end

  rcc_src_arbiter #(.N(NSRC)) i_arb (
    .req_i   (req_vec),
    .grant_o (grant),
    .any_o   (any_req)
  );

  always_comb begin
    por_pattern          = {FLAG_W{POR_FLAG_FILL}};
    por_pattern[BIT_SUP] = 1'b1;
  end

  always_comb begin
    flags_d = grant[IDX_SUP] ? por_pattern : '0;
    for (int unsigned s = 1; s < NSRC; s++) begin
      flags_d[flag_pos(s)] = flags_d[flag_pos(s)] | grant[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= por_pattern;
    else if (any_req) flags_q <= flags_d;
  end

  rcc_hold_timer #(.HOLD(HOLD_CYCLES)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (any_req),
    .active_o (sys_rst_o)
  );

  assign bus_rdata_o = (bus_addr_i == ADDR) ? {1'b0, flags_q} : '0;

  p_bit7_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rdata_o[7]);

  p_idle_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> $stable(flags_q));

  p_cmp_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_cmp |-> !grant[IDX_CMP]);

  p_mcd_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_mcd |-> !grant[IDX_MCD]);

  p_sw_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req && req_vec[NSRC-2:0] == '0) |=> (flags_q[BIT_SW] && sys_rst_o));

  if (POR_FLAG_FILL == 1'b0) begin : g_onehot_chk
    p_single_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(flags_q));
  end
endmodule

// File: tb/test_reset_cause_unit.sv
module test_reset_cause_unit;
  localparam logic [7:0] ADDR = 8'hEF;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_req = 0, pin_req = 0, mcd_req = 0, wdog_req = 0, cmp_req = 0, flash_req = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = ADDR;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sys_rst;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  reset_cause_unit #(.ADDR(ADDR), .HOLD_CYCLES(HOLD)) i_reset_cause_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .sup_req_i(sup_req), .pin_req_i(pin_req), .mcd_req_i(mcd_req),
    .wdog_req_i(wdog_req), .cmp_req_i(cmp_req), .flash_req_i(flash_req),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .sys_rst_o(sys_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (sys_rst && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = ADDR; bus_wdata = '0;
  endtask

  task automatic read_reg(output logic [7:0] v);
    bus_addr = ADDR;
    #1 v = bus_rdata;
  endtask

  // m bits: 0 sup,1 pin,2 mcd,3 wdog,4 cmp,5 flash,6 sw ; wcfg = enable bits for sw write
  task automatic fire(input logic [6:0] m, input logic [7:0] wcfg, output int n_high);
    @(negedge clk);
    sup_req = m[0]; pin_req = m[1]; mcd_req = m[2]; wdog_req = m[3];
    cmp_req = m[4]; flash_req = m[5];
    if (m[6]) begin
      bus_wr = 1'b1; bus_addr = ADDR; bus_wdata = wcfg | 8'h10;
    end
    @(negedge clk);
    {sup_req, pin_req, mcd_req, wdog_req, cmp_req, flash_req, bus_wr} = '0;
    bus_wdata = '0;
    n_high = 0;
    while (sys_rst && n_high < 100) begin
      n_high++;
      @(negedge clk);
    end
  endtask

  task automatic por_pulse(output int n_high, output logic [7:0] v);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 read_reg(v);
    check(sys_rst === 1'b1, "R1 sys_rst during rst_ni", int'(sys_rst), 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    n_high = 0;
    while (sys_rst && n_high < 100) begin
      n_high++;
      @(negedge clk);
    end
  endtask

  function automatic int flag_bit(input int idx);
    case (idx)
      0: return 1; 1: return 0; 2: return 2; 3: return 3;
      4: return 5; 5: return 6; default: return 4;
    endcase
  endfunction

  initial begin
    #1_500_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_flags;
    int n;

    // R1 power-on
    por_pulse(n, v);
    check(v == 8'h02, "R1 flags during reset", v, 8'h02);
    check(n == HOLD, "R1 hold after release", n, HOLD);
    read_reg(v);
    check(v == 8'h02, "R1 flags after release", v, 8'h02);

    // R11 other address
    bus_addr = 8'hEE; #1;
    check(bus_rdata == 8'h00, "R11 read other addr", bus_rdata, 0);
    bus_addr = ADDR;
    bus_write(8'hEE, 8'h10);
    check(sys_rst == 1'b0, "R11 sw write other addr", int'(sys_rst), 0);

    // R4 bit4 clear: no reset; R2 bit7 ignored
    bus_write(ADDR, 8'h82);
    check(sys_rst == 1'b0, "R4 write bit4=0 no reset", int'(sys_rst), 0);
    read_reg(v);
    check(v == 8'h02, "R2 bit7 reads 0", v, 8'h02);
    bus_write(ADDR, 8'h80 | 8'h20);
    fire(7'b0010000, 8'h00, n);
    check(n == HOLD, "R2 bit7 write kept cmp enable", n, HOLD);
    read_reg(v);
    check(v == 8'h20, "R5 cmp flag", v, 8'h20);

    // near-exhaustive sweep: enables x request subsets
    exp_flags = v;
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 128; m++) begin
        logic [7:0] wcfg;
        logic [6:0] q;
        int win;
        wcfg = {2'b00, e[2], 2'b00, e[1], e[0], 1'b0};
        wait_idle();
        bus_write(ADDR, wcfg);
        q = m[6:0];
        q[0] = q[0] & e[0];
        q[2] = q[2] & e[1];
        q[4] = q[4] & e[2];
        win = -1;
        for (int s = 6; s >= 0; s--) if (q[s]) win = s;
        fire(m[6:0], wcfg, n);
        read_reg(v);
        if (win < 0) begin
          check(n == 0, "R5 R6 R7 masked requests no reset", n, 0);
        end else begin
          exp_flags = (win == 0) ? 8'h02 : (8'h01 << flag_bit(win));
          check(n == HOLD, "R9 hold length", n, HOLD);
        end
        check(v == exp_flags, "R10 R3 R4 winner flag", v, exp_flags);
      end
    end

    // R9 restart of hold by a later request
    wait_idle();
    fire(7'b0000010, 8'h00, n);
    wait_idle();
    @(negedge clk); pin_req = 1'b1;
    @(negedge clk); pin_req = 1'b0;
    repeat (5) @(negedge clk);
    fire(7'b0001000, 8'h00, n);
    check(n == HOLD, "R9 restart hold", n, HOLD);
    read_reg(v);
    check(v == 8'h08, "R3 watchdog flag", v, 8'h08);

    // R12 write during hold ignored
    bus_write(ADDR, 8'h02);
    @(negedge clk); flash_req = 1'b1;
    @(negedge clk); flash_req = 1'b0;
    bus_write(ADDR, 8'h30);
    wait_idle();
    read_reg(v);
    check(v == 8'h40, "R12 write in hold no sw flag", v, 8'h40);
    fire(7'b0010000, 8'h00, n);
    check(n == 0, "R12 write in hold kept cmp off", n, 0);

    // R8 enables survive non-POR reset
    bus_write(ADDR, 8'h24);
    fire(7'b0000010, 8'h00, n);
    fire(7'b0010000, 8'h00, n);
    check(n == HOLD, "R8 cmp enable survives pin reset", n, HOLD);
    fire(7'b0000100, 8'h00, n);
    check(n == HOLD, "R8 mcd enable survives", n, HOLD);
    read_reg(v);
    check(v == 8'h04, "R6 mcd flag", v, 8'h04);
    fire(7'b0000001, 8'h00, n);
    check(n == 0, "R7 supply disabled ignored", n, 0);

    // R8 POR clears enables, supply default on
    por_pulse(n, v);
    fire(7'b0010100, 8'h00, n);
    check(n == 0, "R8 POR cleared cmp/mcd enables", n, 0);
    fire(7'b0000001, 8'h00, n);
    check(n == HOLD, "R7 R8 supply enabled after POR", n, HOLD);
    read_reg(v);
    check(v == 8'h02, "R7 supply flag", v, 8'h02);

    // R4 sw reset alone
    fire(7'b1000000, 8'h02, n);
    check(n == HOLD, "R4 sw reset hold", n, HOLD);
    read_reg(v);
    check(v == 8'h10, "R4 sw flag", v, 8'h10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule